// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit multiplies two signed operands and adds the product to a 64-bit accumulator. The accumulator is held as two 32-bit halves, a high word and a low word. A long operation takes the full 32-bit operands. A word operation uses only the low 16 bits of each operand. A saturation input selects the overflow policy.

With saturation off, both operations add into the whole 64-bit accumulator and wrap as two's complement. With saturation on, a long operation keeps the result inside a signed 48-bit window. A saturated word operation works on the low word alone as a 32-bit adder. If that adder overflows, the low word is clamped and the high word is set to 1 as an overflow marker.

Software-style access is limited to write strobes for each half and a clear. Both halves can always be read. One cycle after a start is accepted, the new accumulator value appears on the outputs and a done pulse marks it.

Top module: `mac_unit`

## Requirements
- R1: After reset both accumulator halves read zero and done_o is low.
- R2: A start accepted at a clock edge updates both halves at that same edge. done_o is high for exactly the following cycle. done_o is never high without an accepted start at the previous edge.
- R3: Long operation (op_i = 0) with sat_i = 0: the signed 64-bit product of opa_i and opb_i is added to the 64-bit accumulator {acc_hi_o, acc_lo_o}, wrapping modulo 2^64.
- R4: Long operation with sat_i = 1: the result stays within -2^47 .. 2^47-1. If the 64-bit sum overflows, the result is -2^47 when the old accumulator was negative and 2^47-1 otherwise. If the sum does not overflow, it is clamped into the 48-bit window.
- R5: Word operation (op_i = 1): each operand is bits [15:0] sign-extended. Bits [31:16] of both operands have no effect.
- R6: Word operation with sat_i = 0: the 32-bit product, sign-extended to 64 bits, is added to the full accumulator with wraparound.
- R7: Word operation with sat_i = 1: the low word and the product are added as signed 32-bit values, and the high word takes no part. On overflow the low word becomes 0x80000000 if the old low word was negative, otherwise 0x7FFFFFFF, and the high word becomes 1. Without overflow the high word is unchanged.
- R8: With no start, ld_hi_i writes ld_data_i into the high word and ld_lo_i writes it into the low word, in the same edge. clr_i zeroes both halves and takes priority over the writes.
- R9: A start in the same cycle as any of ld_hi_i, ld_lo_i or clr_i is ignored entirely. No half changes and no done pulse follows.
- R10: In a cycle with no start, no write and no clear, both halves hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one multiply-accumulate |
| op_i | input | 1 | 0 = long (32x32), 1 = word (16x16) |
| sat_i | input | 1 | Saturating arithmetic enable |
| opa_i | input | 32 | First signed operand |
| opb_i | input | 32 | Second signed operand |
| ld_hi_i | input | 1 | Write ld_data_i into the high word |
| ld_lo_i | input | 1 | Write ld_data_i into the low word |
| clr_i | input | 1 | Zero both accumulator halves |
| ld_data_i | input | 32 | Data for the half writes |
| acc_hi_o | output | 32 | Accumulator high word |
| acc_lo_o | output | 32 | Accumulator low word |
| done_o | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The properties assume the inputs are driven low while reset is held, so the first post-reset look into the past sees no start. They also assume op_i and sat_i are known whenever start_i is high. The stimulus changes every input only on the falling edge and returns start_i and the write strobes to zero between operations. The single deliberate violation of the access rule, a start paired with a write, exercises the ignore path without breaking any property's premise. Operands mix the listed corner vectors with random values drawn heavily from the extremes (most positive, most negative, minus one, and 16-bit limits) so that every saturation branch is reached.

// File: rtl/mac_pkg.sv
package mac_pkg;

    parameter int unsigned MAC_DATA_W = 32;
    parameter int unsigned MAC_SAT_W  = 48;

    typedef enum logic {
        MAC_OP_LONG = 1'b0,
        MAC_OP_WORD = 1'b1
    } mac_op_e;

endpackage

// File: rtl/mac_product.sv
// Signed product of the two operands, 2*OPW bits wide.
// Long mode uses the full operands; word mode uses the low halves.
module mac_product
    import mac_pkg::*;
#(
    parameter int unsigned OPW = 32
) (
    input  mac_op_e          op_i,
    input  logic [OPW-1:0]   opa_i,
    input  logic [OPW-1:0]   opb_i,
    output logic [2*OPW-1:0] prod_o
);
    localparam int unsigned HW  = OPW / 2;
    localparam int unsigned PW  = 2 * OPW;

    logic signed [PW-1:0] a_long, b_long, a_word, b_word;
    logic signed [PW-1:0] p_long, p_word;

    always_comb begin
        a_long = {{OPW{opa_i[OPW-1]}}, opa_i};
        b_long = {{OPW{opb_i[OPW-1]}}, opb_i};
        a_word = {{(PW-HW){opa_i[HW-1]}}, opa_i[HW-1:0]};
        b_word = {{(PW-HW){opb_i[HW-1]}}, opb_i[HW-1:0]};
        p_long = a_long * b_long;
        p_word = a_word * b_word;
        prod_o = (op_i == MAC_OP_WORD) ? p_word : p_long;
    end

endmodule

// File: rtl/mac_sat_long.sv
// Full-width accumulate with an optional clamp to a narrower signed window.
module mac_sat_long #(
    parameter int unsigned AW = 64,
    parameter int unsigned SW = 48
) (
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] add_i,
    input  logic          sat_en_i,
    output logic [AW-1:0] res_o
);
    localparam logic [AW-1:0] MAX_V = {{(AW-SW+1){1'b0}}, {(SW-1){1'b1}}};
    localparam logic [AW-1:0] MIN_V = ~MAX_V;

    logic [AW-1:0] sum;
    logic          wrap;
    logic          fits;

    assign sum  = acc_i + add_i;
    assign wrap = (acc_i[AW-1] == add_i[AW-1]) && (sum[AW-1] != acc_i[AW-1]);

    generate
        if (SW < AW) begin : g_window
            assign fits = (&sum[AW-1:SW-1]) || ~(|sum[AW-1:SW-1]);
        end else begin : g_full
            assign fits = 1'b1;
        end
    endgenerate

    always_comb begin
        res_o = sum;
        if (sat_en_i) begin
            if (wrap) begin
                res_o = acc_i[AW-1] ? MIN_V : MAX_V;
            end else if (!fits) begin
                res_o = sum[AW-1] ? MIN_V : MAX_V;
            end
        end
    end

endmodule

// File: rtl/mac_sat_word.sv
// Saturating 32-bit accumulate on the low word; high word becomes an overflow marker.
module mac_sat_word #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] lo_i,
    input  logic [DW-1:0] add_i,
    output logic [DW-1:0] hi_o,
    output logic [DW-1:0] lo_o
);
    localparam logic [DW-1:0] MAX_V = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MARK  = DW'(1);

    logic [DW-1:0] sum;
    logic          ovf;

    assign sum = lo_i + add_i;
    assign ovf = (lo_i[DW-1] == add_i[DW-1]) && (sum[DW-1] != lo_i[DW-1]);

    always_comb begin
        hi_o = hi_i;
        lo_o = sum;
        if (ovf) begin
            lo_o = lo_i[DW-1] ? MIN_V : MAX_V;
            hi_o = MARK;
        end
    end

endmodule

// File: rtl/mac_unit.sv
// Multiply-accumulate unit with split accumulator and two saturation policies.
module mac_unit
    import mac_pkg::*;
#(
    parameter int unsigned DATA_W = MAC_DATA_W,
    parameter int unsigned SAT_W  = MAC_SAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic              sat_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              ld_hi_i,
    input  logic              ld_lo_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] ld_data_i,
    output logic [DATA_W-1:0] acc_hi_o,
    output logic [DATA_W-1:0] acc_lo_o,
    output logic              done_o
);
    localparam int unsigned ACC_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    mac_op_e           op_sel;
    logic [ACC_W-1:0]  prod;
    logic [ACC_W-1:0]  long_res;
    logic [DATA_W-1:0] word_hi, word_lo;
    logic              any_wr;

    assign op_sel = mac_op_e'(op_i);
    assign any_wr = ld_hi_i | ld_lo_i | clr_i;

    mac_product #(.OPW(DATA_W)) u_prod (
        .op_i   (op_sel),
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .prod_o (prod)
    );

    mac_sat_long #(.AW(ACC_W), .SW(SAT_W)) u_long (
        .acc_i    ({st_q.hi, st_q.lo}),
        .add_i    (prod),
        .sat_en_i (sat_i && (op_sel == MAC_OP_LONG)),
        .res_o    (long_res)
    );

    mac_sat_word #(.DW(DATA_W)) u_word (
        .hi_i  (st_q.hi),
        .lo_i  (st_q.lo),
        .add_i (prod[DATA_W-1:0]),
        .hi_o  (word_hi),
        .lo_o  (word_lo)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            if (!any_wr) begin
                st_d.done = 1'b1;
                if (op_sel == MAC_OP_WORD && sat_i) begin
                    st_d.hi = word_hi;
                    st_d.lo = word_lo;
                end else begin
                    {st_d.hi, st_d.lo} = long_res;
                end
            end
        end else if (clr_i) begin
            st_d.hi = '0;
            st_d.lo = '0;
        end else begin
            if (ld_hi_i) st_d.hi = ld_data_i;
            if (ld_lo_i) st_d.lo = ld_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_hi_o = st_q.hi;
    assign acc_lo_o = st_q.lo;
    assign done_o   = st_q.done;

endmodule

// File: rtl/mac_unit_chk.sv
// Protocol and range properties for mac_unit.
module mac_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SAT_W  = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              op_i,
    input logic              sat_i,
    input logic              ld_hi_i,
    input logic              ld_lo_i,
    input logic              clr_i,
    input logic [DATA_W-1:0] acc_hi_o,
    input logic [DATA_W-1:0] acc_lo_o,
    input logic              done_o
);
    localparam int unsigned TOP_B = 2 * DATA_W - SAT_W + 1;

    logic wr;
    logic [TOP_B-1:0] top_bits;
    assign wr       = ld_hi_i | ld_lo_i | clr_i;
    assign top_bits = acc_hi_o[DATA_W-1:DATA_W-TOP_B];

    p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !wr |=> done_o);

    p_done_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i && !wr));

    p_ignore_collision_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && wr |=> !done_o && $stable(acc_hi_o) && $stable(acc_lo_o));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i && !wr |=> $stable(acc_hi_o) && $stable(acc_lo_o));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !start_i |=> acc_hi_o == '0 && acc_lo_o == '0);

    p_long_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && $past(op_i == 1'b0 && sat_i) |-> (&top_bits) || ~(|top_bits));

    p_word_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && $past(op_i == 1'b1 && sat_i) && (acc_hi_o != $past(acc_hi_o))
        |-> acc_hi_o == DATA_W'(1));

endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W), .SAT_W(SAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .sat_i    (sat_i),
    .ld_hi_i  (ld_hi_i),
    .ld_lo_i  (ld_lo_i),
    .clr_i    (clr_i),
    .acc_hi_o (acc_hi_o),
    .acc_lo_o (acc_lo_o),
    .done_o   (done_o)
);

// File: tb/tb_mac_unit.sv
module tb_mac_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic        sat_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        ld_hi_i = 1'b0;
    logic        ld_lo_i = 1'b0;
    logic        clr_i = 1'b0;
    logic [31:0] ld_data_i = '0;
    logic [31:0] acc_hi_o, acc_lo_o;
    logic        done_o;

    always #5 clk = ~clk;

    mac_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .sat_i(sat_i),
        .opa_i(opa_i), .opb_i(opb_i), .ld_hi_i(ld_hi_i), .ld_lo_i(ld_lo_i),
        .clr_i(clr_i), .ld_data_i(ld_data_i), .acc_hi_o(acc_hi_o),
        .acc_lo_o(acc_lo_o), .done_o(done_o)
    );

    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [63:0] model_acc = '0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    localparam logic signed [127:0] MAX48 = 128'sh7fff_ffff_ffff;
    localparam logic signed [127:0] MIN48 = -MAX48 - 128'sd1;
    localparam logic signed [127:0] MAX32 = 128'sh7fff_ffff;
    localparam logic signed [127:0] MIN32 = -MAX32 - 128'sd1;

    // Behavioural reference in 128-bit arithmetic.
    function automatic logic [63:0] ref_mac(logic op, logic sat, logic [63:0] acc,
                                           logic [31:0] a, logic [31:0] b);
        logic signed [127:0] sa, sb, sp, sum;
        if (op == 1'b0) begin
            sa = {{96{a[31]}}, a};
            sb = {{96{b[31]}}, b};
        end else begin
            sa = {{112{a[15]}}, a[15:0]};
            sb = {{112{b[15]}}, b[15:0]};
        end
        sp = sa * sb;
        if (op == 1'b1 && sat) begin
            sum = {{96{acc[31]}}, acc[31:0]} + sp;
            if (sum > MAX32) return {32'd1, 32'h7fff_ffff};
            if (sum < MIN32) return {32'd1, 32'h8000_0000};
            return {acc[63:32], sum[31:0]};
        end
        sum = {{64{acc[63]}}, acc} + sp;
        if (op == 1'b0 && sat) begin
            if (sum > MAX48) return 64'h0000_7fff_ffff_ffff;
            if (sum < MIN48) return 64'hffff_8000_0000_0000;
        end
        return sum[63:0];
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one operation, expected value pushed to the scoreboard.
    task automatic do_op(logic op, logic sat, logic [31:0] a, logic [31:0] b, string tag);
        @(negedge clk);
        start_i = 1'b1; op_i = op; sat_i = sat; opa_i = a; opb_i = b;
        model_acc = ref_mac(op, sat, model_acc, a, b);
        exp_q.push_back(model_acc);
        tag_q.push_back(tag);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic load(logic [63:0] v);
        @(negedge clk);
        ld_hi_i = 1'b1; ld_lo_i = 1'b1; ld_data_i = v[63:32];
        ld_lo_i = 1'b0;
        @(negedge clk);
        ld_hi_i = 1'b0; ld_lo_i = 1'b1; ld_data_i = v[31:0];
        @(negedge clk);
        ld_lo_i = 1'b0;
        model_acc = v;
    endtask

    task automatic wait_drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 10) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Monitor: pops the scoreboard whenever a result is marked.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R2/R9: unexpected done, actual acc %h expected no pulse",
                         {acc_hi_o, acc_lo_o});
            end else begin
                check64(tag_q.pop_front(), {acc_hi_o, acc_lo_o}, exp_q.pop_front());
            end
        end
    end

    function automatic logic [31:0] pick32();
        case ($urandom % 8)
            0: return 32'h7fff_ffff;
            1: return 32'h8000_0000;
            2: return 32'hffff_ffff;
            3: return {$urandom % 65536, 16'h7fff};
            4: return {$urandom % 65536, 16'h8000};
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [63:0] pick64();
        case ($urandom % 6)
            0: return 64'h7fff_ffff_ffff_ffff;
            1: return 64'h8000_0000_0000_0000;
            2: return 64'h0000_7fff_ffff_0000;
            3: return {$urandom, 32'h7fff_fff0};
            default: return {$urandom, $urandom};
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check64("R1 reset acc", {acc_hi_o, acc_lo_o}, 64'd0);
        n_checks++;
        if (done_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 done: actual %b expected 0", done_o);
        end

        // R8: independent half writes and readback
        load(64'h1122_3344_5566_7788);
        check64("R8 load both halves", {acc_hi_o, acc_lo_o}, 64'h1122_3344_5566_7788);
        @(negedge clk); ld_hi_i = 1'b1; ld_data_i = 32'hdead_beef;
        @(negedge clk); ld_hi_i = 1'b0;
        model_acc[63:32] = 32'hdead_beef;
        check64("R8 high only", {acc_hi_o, acc_lo_o}, model_acc);
        // R8: clear wins over writes
        @(negedge clk); clr_i = 1'b1; ld_lo_i = 1'b1; ld_data_i = 32'h1234_5678;
        @(negedge clk); clr_i = 1'b0; ld_lo_i = 1'b0;
        model_acc = '0;
        check64("R8 clear priority", {acc_hi_o, acc_lo_o}, 64'd0);

        // R3/R4: listed long vectors
        load(64'h0000_7fff_1234_5678);
        do_op(1'b0, 1'b0, 32'h7fff_ffff, 32'h7fff_ffff, "R3 long big unsat");
        wait_drain();
        check64("R3 value", model_acc, 64'h4000_7ffe_1234_5679);
        load(64'h0000_7fff_1234_5678);
        do_op(1'b0, 1'b1, 32'h7fff_ffff, 32'h7fff_ffff, "R4 long big sat");
        wait_drain();
        check64("R4 value", model_acc, 64'h0000_7fff_ffff_ffff);
        load(64'h8000_0000_0000_0000);
        do_op(1'b0, 1'b0, 32'hffff_ffff, 32'h0000_0001, "R3 long wrap unsat");
        wait_drain();
        check64("R3 wrap value", model_acc, 64'h7fff_ffff_ffff_ffff);
        load(64'h8000_0000_0000_0000);
        do_op(1'b0, 1'b1, 32'hffff_ffff, 32'h0000_0001, "R4 long ovf sat");
        wait_drain();
        check64("R4 ovf value", model_acc, 64'hffff_8000_0000_0000);

        // R6/R7: listed word vectors
        load(64'habcd_ef12_7fff_fffa);
        do_op(1'b1, 1'b0, 32'h0000_0002, 32'h0000_0003, "R6 word unsat");
        wait_drain();
        check64("R6 value", model_acc, 64'habcd_ef12_8000_0000);
        load(64'habcd_ef12_7fff_fffa);
        do_op(1'b1, 1'b1, 32'h0000_0002, 32'h0000_0003, "R7 word sat ovf");
        wait_drain();
        check64("R7 value", model_acc, 64'h0000_0001_7fff_ffff);
        // R7: no overflow leaves high word
        load(64'habcd_ef12_0000_0010);
        do_op(1'b1, 1'b1, 32'h0000_ffff, 32'h0000_0003, "R7 word sat no ovf");
        // R5: upper operand bits ignored in word mode
        do_op(1'b1, 1'b0, 32'h9abc_0005, 32'h7777_fffd, "R5 word upper bits ignored");
        wait_drain();

        // R9: start together with a write is dropped
        @(negedge clk);
        start_i = 1'b1; op_i = 1'b0; sat_i = 1'b0; opa_i = 32'h7fff_ffff; opb_i = 32'h7fff_ffff;
        ld_lo_i = 1'b1; ld_data_i = 32'h5555_aaaa;
        @(negedge clk);
        start_i = 1'b0; ld_lo_i = 1'b0;
        @(negedge clk);
        check64("R9 collision ignored", {acc_hi_o, acc_lo_o}, model_acc);
        // R10: idle hold over several cycles
        repeat (3) @(negedge clk);
        check64("R10 idle hold", {acc_hi_o, acc_lo_o}, model_acc);

        // Random sweep, both ops and both modes, back to back
        for (int i = 0; i < 300; i++) begin
            if (i % 4 == 0) load(pick64());
            do_op(1'($urandom % 2), 1'($urandom % 2), pick32(), pick32(), "R3/R4/R6/R7 random");
        end
        wait_drain();
        repeat (2) @(negedge clk);
        check64("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

endmodule